// File: doc/BRIEF.md
# MDIO Management Master Controller

This block acts as the station-management master on a two-wire PHY management bus. It generates the management clock (MDC) from the system clock through a programmable divider. It also drives the shared, open-drain data line (MDIO) by pulling it low or letting the pull-up hold it high. Software sets up the target through a small four-word register port: a configuration word, a 16-bit extended register address, an access word and a status word.

Writing the access word launches a write transaction carrying the low 16 bits of the written value. Reading the access word launches a read transaction. Each frame is sent after a 32-bit idle preamble. The block supports two frame formats:
- the short format, which needs a single frame;
- the extended format, which needs two steps. An address frame loads the 16-bit register address, and a data frame then performs the write, the read, or a read with post-increment.

Read data is shifted into the status word. A completion flag, also brought out as an interrupt, marks the end of the whole transaction.

Top module: `mdio_master`

## Requirements
- R1: Every frame, including each of the two frames of an extended access, is preceded by 32 bit periods in which the master does not pull MDIO low.
- R2: A short-format frame is sent MSB first as follows: start 01, opcode (01 for write, 10 for read), 5-bit PHY address (cfg[4:0]), 5-bit register address (cfg[9:5]), turnaround, then 16 data bits. For a write the turnaround is 10 and the data bits are the written data.
- R3: In a read frame the master releases MDIO for both turnaround bits and all 16 data bits. It samples the data MSB first on MDC rising edges into status[15:0].
- R4: When cfg[15] is 1, an access sends two frames, both with start 00, the port address cfg[4:0] and the device address cfg[9:5]. The first is an address frame: opcode 00, turnaround 10, and the register-address word (offset 1) as data. The second uses opcode 01 for write and 11 for read, or 10 for read when cfg[14] is 1.
- R5: A write to offset 2 launches a write transaction with data reg_wdata[15:0]. A read of offset 2 launches a read transaction.
- R6: MDIO is open-drain. The block only ever asserts a pull-low, and it leaves the line released whenever no transaction is in progress.
- R7: MDC is low when idle, and its half period is cfg[23:16] system clocks, with 0 treated as 1. The master changes MDIO only just after an MDC falling edge.
- R8: status[16] (busy) is 1 from launch until the last bit of the transaction. While busy, writes to offsets 0, 1 and 2 and reads of offset 2 are ignored.
- R9: The completion flag status[17], mirrored on irq, rises when busy falls. It is cleared by reading offset 3 or by the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset: 0 config, 1 register address, 2 access, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Sensed level of the MDIO line |
| mdio_drive_low | output | 1 | Pull-low enable for the open-drain MDIO pad |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps the divider across 0 to 3 and runs both directions with several address and data patterns. It models a PHY on a wired-AND line and compares every captured bit against a frame assembled from the requirements. If the stream is misplaced by one bit, or the preamble is short, the wrong opcode or turnaround is sent, or the divider is off by one, the captured stream or the measured MDC period no longer matches. The extended-format runs catch a design that skips the address step, uses the wrong start code, or ignores post-increment. A deliberate second launch and configuration writes while busy catch a design that restarts mid-frame or lets the addressing change under it. Status reads after each run catch a completion flag that never rises or never clears.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_in,
  output logic        mdio_drive_low,
  output logic        irq
);
  localparam int PRE_BITS   = 32;
  localparam int TOT        = PRE_BITS + 32;
  localparam int CW         = $clog2(TOT);
  localparam int DATA_START = TOT - 16;
  localparam int CFG_W      = 16 + DIV_W;

  logic [CFG_W-1:0] cfg_q;
  logic [15:0]      rega_q, wd_q, rdata_q;
  logic             busy, step, is_rd, mdc_q, done;
  logic [DIV_W-1:0] cnt;
  logic [CW-1:0]    bitcnt;
  logic [TOT-1:0]   sr;

  wire [4:0]       prt = cfg_q[4:0];
  wire [4:0]       dev = cfg_q[9:5];
  wire             pinc = cfg_q[14];
  wire             c45 = cfg_q[15];
  wire [DIV_W-1:0] div = cfg_q[16 +: DIV_W];
  wire [DIV_W-1:0] lim = (div == '0) ? DIV_W'(1) : div;
  wire             tick = busy && (cnt >= lim - 1'b1);
  wire             rise = tick && !mdc_q;
  wire             fall = tick && mdc_q;
  wire             hit = (reg_addr == 2'd2) && !busy;
  wire             go_wr = reg_wr && hit;
  wire             go_rd = reg_rd && hit;
  wire             cfg_ok = reg_wr && !busy;

  logic unused_hi;
  assign unused_hi = ^reg_wdata[31:CFG_W];

  function automatic logic [TOT-1:0] frame(input logic astep, input logic rd, input logic [15:0] w);
    logic [1:0]  op, ta;
    logic [15:0] pay;
    if (astep) begin
      op = 2'b00; ta = 2'b10; pay = rega_q;
    end else begin
      if (c45) op = rd ? (pinc ? 2'b10 : 2'b11) : 2'b01;
      else     op = rd ? 2'b10 : 2'b01;
      ta  = rd ? 2'b11 : 2'b10;
      pay = rd ? 16'hFFFF : w;
    end
    return {{PRE_BITS{1'b1}}, (c45 ? 2'b00 : 2'b01), op, prt, dev, ta, pay};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; rega_q <= '0; wd_q <= '0; rdata_q <= '0;
      busy <= 1'b0; step <= 1'b0; is_rd <= 1'b0; mdc_q <= 1'b0; done <= 1'b0;
      cnt <= '0; bitcnt <= '0; sr <= '1;
    end else begin
      if (cfg_ok && reg_addr == 2'd0) cfg_q <= reg_wdata[CFG_W-1:0];
      if (cfg_ok && reg_addr == 2'd1) rega_q <= reg_wdata[15:0];
      if (reg_rd && reg_addr == 2'd3) done <= 1'b0;
      if (go_wr || go_rd) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        is_rd  <= go_rd;
        wd_q   <= reg_wdata[15:0];
        step   <= c45;
        sr     <= frame(c45, go_rd, reg_wdata[15:0]);
        bitcnt <= '0;
        cnt    <= '0;
        mdc_q  <= 1'b0;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) mdc_q <= !mdc_q;
        if (rise && is_rd && !step && bitcnt >= CW'(DATA_START))
          rdata_q <= {rdata_q[14:0], mdio_in};
        if (fall) begin
          if (bitcnt == CW'(TOT - 1)) begin
            if (step) begin
              step   <= 1'b0;
              sr     <= frame(1'b0, is_rd, wd_q);
              bitcnt <= '0;
            end else begin
              busy <= 1'b0;
              done <= 1'b1;
              sr   <= '1;
            end
          end else begin
            sr     <= {sr[TOT-2:0], 1'b1};
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
    end
  end

  assign mdc            = mdc_q;
  assign mdio_drive_low = busy && !sr[TOT-1];
  assign irq            = done;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(cfg_q);
      2'd1:    reg_rdata = {16'h0, rega_q};
      default: reg_rdata = {14'h0, done, busy, rdata_q};
    endcase
  end

  // R1
  preamble_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bitcnt < CW'(PRE_BITS) |-> !mdio_drive_low);

  // R3
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && is_rd && !step && bitcnt >= CW'(DATA_START - 2) |-> !mdio_drive_low);

  // R7
  mdio_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && !$stable(mdio_drive_low) |-> $past(fall));

  // R7
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc_q);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cfg_q) && $stable(rega_q));

  // R9
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_drive_low, irq;
  logic        phy_out = 1'b1;
  logic        phy_en = 1'b0;
  logic [15:0] phy_data = '0;
  int          base = 0;
  logic [127:0] cap = '0;
  int          ncap = 0;
  time         t1 = 0, t2 = 0;
  int          tests = 0, fails = 0;
  wire         line = !mdio_drive_low && phy_out;

  always #4 clk = !clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_in(line),
    .mdio_drive_low(mdio_drive_low), .irq(irq)
  );

  always @(posedge mdc) begin
    if (ncap == 0) t1 = $time;
    if (ncap == 1) t2 = $time;
    cap = {cap[126:0], line};
    ncap = ncap + 1;
  end

  always @(negedge mdc)
    phy_out = (phy_en && ncap >= base + 48 && ncap < base + 64) ? phy_data[15 - (ncap - base - 48)] : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk(irq, "R9 completion", {127'b0, irq}, 128'd1);
  endtask

  function automatic logic [63:0] ef(bit c45, bit astep, bit rd, bit pinc, logic [4:0] p, logic [4:0] d,
                                     logic [15:0] ra, logic [15:0] v);
    logic [1:0] st, op, ta;
    logic [15:0] pay;
    st = c45 ? 2'b00 : 2'b01;
    if (astep) op = 2'b00;
    else if (c45) op = rd ? (pinc ? 2'b10 : 2'b11) : 2'b01;
    else op = rd ? 2'b10 : 2'b01;
    ta  = (astep || !rd) ? 2'b10 : 2'b11;
    pay = astep ? ra : v;
    return {32'hFFFF_FFFF, st, op, p, d, ta, pay};
  endfunction

  task automatic run_op(bit c45, bit pinc, bit rd, int dv, logic [4:0] p, logic [4:0] d,
                        logic [15:0] ra, logic [15:0] v);
    logic [31:0] st, junk;
    logic [127:0] exp;
    int nexp, lim;
    reg_write(2'd0, {8'b0, 8'(dv), c45, pinc, 4'b0, d, p});
    reg_write(2'd1, {16'b0, ra});
    phy_data = v; phy_en = rd; base = c45 ? 64 : 0; ncap = 0; cap = '0;
    if (rd) reg_read(2'd2, junk);
    else reg_write(2'd2, {16'hDEAD, v});
    wait_irq();
    nexp = c45 ? 128 : 64;
    exp = c45 ? {ef(1, 1, rd, pinc, p, d, ra, v), ef(1, 0, rd, pinc, p, d, ra, v)}
              : {64'b0, ef(0, 0, rd, pinc, p, d, ra, v)};
    chk(ncap == nexp, "R5 bit count", 128'(ncap), 128'(nexp));
    chk(cap[nexp-1 -: 32] == 32'hFFFF_FFFF, "R1 preamble", cap[nexp-1 -: 32], 128'hFFFF_FFFF);
    if (c45) chk(cap == exp, "R4 extended frames", cap, exp);
    else chk(cap == exp, rd ? "R3 short read frame" : "R2 short write frame", cap, exp);
    lim = (dv == 0) ? 1 : dv;
    chk((t2 - t1) == time'(16 * lim), "R7 mdc period", 128'(t2 - t1), 128'(16 * lim));
    reg_read(2'd3, st);
    chk(st[17] == 1'b1 && st[16] == 1'b0, "R8 busy clear, R9 done set", 128'(st[17:16]), 128'd2);
    if (rd) chk(st[15:0] == v, "R3 read data", 128'(st[15:0]), 128'(v));
    chk(irq == 1'b0, "R9 cleared by status read", 128'(irq), 128'd0);
    chk(mdio_drive_low == 1'b0, "R6 line released when idle", 128'(mdio_drive_low), 128'd0);
    phy_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] st;
    logic [63:0] first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mdc == 1'b0, "R7 mdc low after reset", 128'(mdc), 128'd0);
    chk(mdio_drive_low == 1'b0, "R6 released after reset", 128'(mdio_drive_low), 128'd0);
    chk(irq == 1'b0, "R9 irq low after reset", 128'(irq), 128'd0);
    reg_read(2'd3, st);
    chk(st[17:16] == 2'b00, "R8 idle after reset", 128'(st[17:16]), 128'd0);

    for (int dv = 0; dv < 4; dv++)
      for (int r = 0; r < 2; r++)
        for (int k = 0; k < 4; k++)
          run_op(1'b0, 1'b0, r[0], dv, 5'((k * 7 + 3) % 32), 5'((k * 13 + 1) % 32), 16'h0,
                 16'h8001 ^ 16'(k * 16'h3C5A) ^ 16'(r * 16'hFFFF));

    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 4; k++)
        run_op(1'b1, m == 2, m != 0, 2, 5'((k * 11 + 5) % 32), 5'((k * 5 + 30) % 32),
               16'hA5C3 ^ 16'(k * 16'h1111), 16'h4E21 + 16'(k * 16'h2B3D));

    reg_write(2'd0, {8'b0, 8'd2, 1'b0, 1'b0, 4'b0, 5'd9, 5'd17});
    reg_write(2'd1, 32'h0000_1234);
    phy_en = 1'b0; base = 0; ncap = 0; cap = '0;
    reg_write(2'd2, 32'h0000_C0DE);
    first = ef(0, 0, 0, 0, 5'd17, 5'd9, 16'h0, 16'hC0DE);
    repeat (20) @(negedge clk);
    reg_read(2'd3, st);
    chk(st[16] == 1'b1, "R8 busy during frame", 128'(st[16]), 128'd1);
    reg_write(2'd0, 32'h00FF_FFFF);
    reg_write(2'd1, 32'h0000_BEEF);
    reg_write(2'd2, 32'h0000_0F0F);
    reg_read(2'd2, st);
    wait_irq();
    repeat (40) @(negedge clk);
    chk(ncap == 64, "R8 no second launch", 128'(ncap), 128'd64);
    chk(cap[63:0] == first, "R8 frame unchanged", cap, 128'(first));
    reg_read(2'd0, st);
    chk(st == 32'h0002_0131, "R8 cfg write ignored", 128'(st), 128'h0002_0131);
    reg_read(2'd1, st);
    chk(st == 32'h0000_1234, "R8 address write ignored", 128'(st), 128'h1234);
    reg_read(2'd3, st);
    chk(irq == 1'b0, "R9 cleared", 128'(irq), 128'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule